// File: doc/BRIEF.md
# Router Pipeline Clock-Gate Controller

This block sits beside a packet router with a four-stage pipeline (buffer write, arbitration, crossbar traversal, output) and produces registered clock-enable signals for every input queue and, per output port, for the output arbiter, the crossbar path and the output stage. Each enable drives a clock-gate cell outside this block. Only the components that lie on the route of a packet in flight are enabled. The controller is not gated: it watches the link valid flags and a narrow tap of each incoming flit at all times.

When a header flit arrives on an idle input, the controller reads the header's type bit, burst field and destination mask. It then holds the input queue enable and the enables of every destination output for the whole packet. The packet ends when its flit count reaches the count that the header implies. The enables pass through a register chain, so each pipeline stage is switched on in the cycle the packet reaches it. A multicast header turns on several output ports at once. Packets that overlap on one output keep it enabled until the later packet has passed.

Top module: `router_cg_ctrl`

## Requirements
- R1: A synchronous active-high reset clears every enable output and ends any packet being tracked. All enables read 0 in the cycle after a reset edge.
- R2: `gate_q[i]` is 1 in the cycle after input i's header is sampled. It stays 1 through the cycle after the packet's last flit is sampled, and then drops.
- R3: Tap word layout for each input, MSB first: kind[1:0] (00 idle, 01 header, 10 address, 11 data), then a write bit, then burst[3:0], then route[NUM_OUT-1:0]. A read packet is 2 flits long. A write packet is 2 + burst flits long. A burst above 8 counts as 8. On a read packet the burst field is ignored.
- R4: Every output o whose route bit is set in the header has `gate_arb[o]` set two cycles after the header is sampled. That enable ends two cycles after the last flit is sampled.
- R5: `gate_xbar` follows the arbiter window one cycle later, and `gate_out` follows it two cycles later. These are three and four cycles after sampling.
- R6: Cycles with the valid flag low inside a packet leave all of that packet's enables on. The packet's lifetime ends only at its last counted flit.
- R7: A valid address or data flit on an idle input is ignored, and so are its route bits. All enables stay 0.
- R8: When packets overlap on an output, or follow each other back to back on one input, each enable is the union of the packets' windows. It stays on until the later packet ends.
- R9: A header with an all-zero route mask enables only its input queue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Router clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | NUM_IN | Per-input flit valid flag |
| in_tap | input | NUM_IN x (7+NUM_OUT) | Per-input flit tap: kind, write, burst, route |
| gate_q | output | NUM_IN | Input queue clock enables |
| gate_arb | output | NUM_OUT | Output arbiter clock enables |
| gate_xbar | output | NUM_OUT | Crossbar path clock enables |
| gate_out | output | NUM_OUT | Output stage clock enables |

## Verification
Take a flit sampled at clock edge c. It shows up on `gate_q` after edge c, on `gate_arb` after edge c+1, on `gate_xbar` after edge c+2 and on `gate_out` after edge c+3. The bench drives inputs on the falling edge. After each rising edge c it reads all four enable groups at the next falling edge. It compares them with the packet windows it has computed from the vector table, shifted by 0, 1, 2 and 3 cycles. Every cycle of every vector is checked until all windows have drained. The directed reset and stray-flit tests read the enables on each falling edge after the edge concerned.

// File: rtl/cgc_pkg.sv
package cgc_pkg;

    localparam int KIND_W    = 2;
    localparam int BURST_W   = 4;
    localparam int MAX_BURST = 8;
    localparam int LEN_W     = 4;
    localparam int TAP_FIXED = KIND_W + 1 + BURST_W;

    // Stage indices of the enable chain behind the first merge register
    localparam int ST_ARB  = 0;
    localparam int ST_XBAR = 1;
    localparam int ST_OUT  = 2;
    localparam int CHAIN_D = ST_OUT + 1;

    typedef enum logic [KIND_W-1:0] {
        K_IDLE = 2'b00,
        K_HEAD = 2'b01,
        K_ADDR = 2'b10,
        K_DATA = 2'b11
    } flit_kind_e;

    typedef struct packed {
        flit_kind_e         kind;
        logic               wr;
        logic [BURST_W-1:0] burst;
    } tap_ctl_t;

    function automatic logic [LEN_W-1:0] pkt_len(input logic wr, input logic [BURST_W-1:0] burst);
        logic [BURST_W-1:0] b;
        b = (burst > BURST_W'(MAX_BURST)) ? BURST_W'(MAX_BURST) : burst;
        return wr ? (LEN_W'(2) + LEN_W'(b)) : LEN_W'(2);
    endfunction

endpackage

// File: rtl/cgc_port_monitor.sv
module cgc_port_monitor
    import cgc_pkg::*;
#(
    parameter int NUM_OUT = 7
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               valid,
    input  logic               head,
    input  logic               wr,
    input  logic [BURST_W-1:0] burst,
    input  logic [NUM_OUT-1:0] route,
    output logic               busy,
    output logic [NUM_OUT-1:0] dest
);

    logic               active;
    logic [LEN_W-1:0]   remain;
    logic [NUM_OUT-1:0] route_r;
    logic               start;

    assign start = head && !active;
    assign busy  = start || active;
    assign dest  = active ? route_r : route;

    always_ff @(posedge clk) begin
        if (rst) begin
            active  <= 1'b0;
            remain  <= '0;
            route_r <= '0;
        end else if (start) begin
            // every packet has at least header and address, so it stays open
            active  <= 1'b1;
            remain  <= pkt_len(wr, burst) - LEN_W'(1);
            route_r <= route;
        end else if (active && valid) begin
            remain <= remain - LEN_W'(1);
            if (remain == LEN_W'(1)) begin
                active <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/cgc_tap_chain.sv
module cgc_tap_chain #(
    parameter int W     = 7,
    parameter int DEPTH = 3
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [W-1:0]              d,
    output logic [DEPTH-1:0][W-1:0]   taps
);

    for (genvar k = 0; k < DEPTH; k++) begin : g_stage
        if (k == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) taps[k] <= '0;
                else     taps[k] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) taps[k] <= '0;
                else     taps[k] <= taps[k-1];
            end
        end
    end

endmodule

// File: rtl/router_cg_ctrl.sv
module router_cg_ctrl
    import cgc_pkg::*;
#(
    parameter  int NUM_IN  = 7,
    parameter  int NUM_OUT = 7,
    localparam int TAP_W   = TAP_FIXED + NUM_OUT
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic [NUM_IN-1:0]            in_valid,
    input  logic [NUM_IN-1:0][TAP_W-1:0] in_tap,
    output logic [NUM_IN-1:0]            gate_q,
    output logic [NUM_OUT-1:0]           gate_arb,
    output logic [NUM_OUT-1:0]           gate_xbar,
    output logic [NUM_OUT-1:0]           gate_out
);

    logic [NUM_IN-1:0]               head_seen;
    logic [NUM_IN-1:0]               busy;
    logic [NUM_IN-1:0][NUM_OUT-1:0]  dest;
    logic [NUM_OUT-1:0]              out_req;
    logic [NUM_IN-1:0]               q_s1;
    logic [NUM_OUT-1:0]              r_s1;
    logic [CHAIN_D-1:0][NUM_OUT-1:0] taps;

    for (genvar i = 0; i < NUM_IN; i++) begin : g_in
        tap_ctl_t ctl;
        assign ctl          = tap_ctl_t'(in_tap[i][TAP_W-1 -: TAP_FIXED]);
        assign head_seen[i] = in_valid[i] && (ctl.kind == K_HEAD);

        cgc_port_monitor #(.NUM_OUT(NUM_OUT)) u_mon (
            .clk   (clk),
            .rst   (rst),
            .valid (in_valid[i]),
            .head  (head_seen[i]),
            .wr    (ctl.wr),
            .burst (ctl.burst),
            .route (in_tap[i][NUM_OUT-1:0]),
            .busy  (busy[i]),
            .dest  (dest[i])
        );
    end

    always_comb begin
        out_req = '0;
        for (int i = 0; i < NUM_IN; i++) begin
            if (busy[i]) out_req = out_req | dest[i];
        end
    end

    // first pipeline stage: queue enables and merged output requests
    always_ff @(posedge clk) begin
        if (rst) begin
            q_s1 <= '0;
            r_s1 <= '0;
        end else begin
            q_s1 <= busy;
            r_s1 <= out_req;
        end
    end

    cgc_tap_chain #(.W(NUM_OUT), .DEPTH(CHAIN_D)) u_chain (
        .clk  (clk),
        .rst  (rst),
        .d    (r_s1),
        .taps (taps)
    );

    assign gate_q    = q_s1;
    assign gate_arb  = taps[ST_ARB];
    assign gate_xbar = taps[ST_XBAR];
    assign gate_out  = taps[ST_OUT];

endmodule

// File: rtl/cgc_checker.sv
module cgc_checker #(
    parameter int NUM_IN  = 7,
    parameter int NUM_OUT = 7
) (
    input logic               clk,
    input logic               rst,
    input logic [NUM_IN-1:0]  head_seen,
    input logic [NUM_IN-1:0]  gate_q,
    input logic [NUM_OUT-1:0] gate_arb,
    input logic [NUM_OUT-1:0] gate_xbar,
    input logic [NUM_OUT-1:0] gate_out
);

    AST_RESET_CLEARS: assert property (@(posedge clk)
        $past(rst) |-> (gate_q == '0 && gate_arb == '0 && gate_xbar == '0 && gate_out == '0)); // R1

    for (genvar i = 0; i < NUM_IN; i++) begin : g_q
        AST_QUEUE_FROM_HEADER: assert property (@(posedge clk) disable iff (rst)
            (!$past(rst) && $rose(gate_q[i])) |-> $past(head_seen[i])); // R2
    end

    AST_ARB_BEHIND_QUEUE: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && (gate_arb != '0)) |-> ($past(gate_q) != '0)); // R4

    AST_XBAR_TRAILS_ARB: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (gate_xbar == $past(gate_arb))); // R5

    AST_OUT_TRAILS_XBAR: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (gate_out == $past(gate_xbar))); // R5

endmodule

bind router_cg_ctrl cgc_checker #(.NUM_IN(NUM_IN), .NUM_OUT(NUM_OUT)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .head_seen (head_seen),
    .gate_q    (gate_q),
    .gate_arb  (gate_arb),
    .gate_xbar (gate_xbar),
    .gate_out  (gate_out)
);

// File: tb/router_cg_ctrl_test.sv
module router_cg_ctrl_test;

    localparam int NI = 7;
    localparam int NO = 7;
    localparam int TW = 7 + NO;

    typedef struct packed {
        logic [2:0] pa; logic wa; logic [3:0] ba; logic [6:0] ma; logic [1:0] gap; logic [3:0] la;
        logic ben; logic [2:0] pb; logic [4:0] sb; logic wb; logic [3:0] bb; logic [6:0] mb; logic [3:0] lb;
    } vec_t;

    // la / lb: packet lengths worked out by hand from R3
    localparam int NV = 10;
    localparam vec_t VECS [NV] = '{
        '{3'd0, 1'b0, 4'd3,  7'h01, 2'd0, 4'd2,  1'b0, 3'd0, 5'd0, 1'b0, 4'd0, 7'h00, 4'd0},
        '{3'd2, 1'b1, 4'd4,  7'h0C, 2'd0, 4'd6,  1'b0, 3'd0, 5'd0, 1'b0, 4'd0, 7'h00, 4'd0},
        '{3'd6, 1'b1, 4'd8,  7'h7F, 2'd0, 4'd10, 1'b0, 3'd0, 5'd0, 1'b0, 4'd0, 7'h00, 4'd0},
        '{3'd1, 1'b1, 4'd15, 7'h50, 2'd0, 4'd10, 1'b0, 3'd0, 5'd0, 1'b0, 4'd0, 7'h00, 4'd0},
        '{3'd3, 1'b1, 4'd0,  7'h20, 2'd0, 4'd2,  1'b0, 3'd0, 5'd0, 1'b0, 4'd0, 7'h00, 4'd0},
        '{3'd4, 1'b1, 4'd2,  7'h02, 2'd2, 4'd4,  1'b0, 3'd0, 5'd0, 1'b0, 4'd0, 7'h00, 4'd0},
        '{3'd0, 1'b1, 4'd3,  7'h06, 2'd0, 4'd5,  1'b1, 3'd5, 5'd3, 1'b1, 4'd4, 7'h04, 4'd6},
        '{3'd2, 1'b0, 4'd0,  7'h01, 2'd0, 4'd2,  1'b1, 3'd2, 5'd2, 1'b1, 4'd1, 7'h40, 4'd3},
        '{3'd5, 1'b1, 4'd1,  7'h00, 2'd0, 4'd3,  1'b0, 3'd0, 5'd0, 1'b0, 4'd0, 7'h00, 4'd0},
        '{3'd1, 1'b0, 4'd7,  7'h41, 2'd0, 4'd2,  1'b1, 3'd3, 5'd0, 1'b0, 4'd2, 7'h01, 4'd2}
    };

    logic                    clk = 1'b0;
    logic                    rst;
    logic [NI-1:0]           in_valid;
    logic [NI-1:0][TW-1:0]   in_tap;
    logic [NI-1:0]           gate_q;
    logic [NO-1:0]           gate_arb;
    logic [NO-1:0]           gate_xbar;
    logic [NO-1:0]           gate_out;

    int checks   = 0;
    int failures = 0;

    always #2 clk = ~clk;

    router_cg_ctrl #(.NUM_IN(NI), .NUM_OUT(NO)) uut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_tap(in_tap),
        .gate_q(gate_q), .gate_arb(gate_arb), .gate_xbar(gate_xbar), .gate_out(gate_out)
    );

    function automatic logic [TW-1:0] mk_tap(input logic [1:0] kind, input logic wr,
                                            input logic [3:0] burst, input logic [NO-1:0] route);
        return {kind, wr, burst, route};
    endfunction

    function automatic string vec_tag(input int v);
        case (v)
            1, 2:    return "R4";
            5:       return "R6";
            6, 7:    return "R8";
            8:       return "R9";
            default: return "R3";
        endcase
    endfunction

    task automatic check_eq(input string tag, input string what, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic check_all_zero(input string tag);
        check_eq(tag, "gate_q",    16'(gate_q),    16'h0);
        check_eq(tag, "gate_arb",  16'(gate_arb),  16'h0);
        check_eq(tag, "gate_xbar", 16'(gate_xbar), 16'h0);
        check_eq(tag, "gate_out",  16'(gate_out),  16'h0);
    endtask

    task automatic run_vector(input int v);
        vec_t x;
        int   end_a, end_b, span;
        x     = VECS[v];
        end_a = int'(x.la) - 1 + int'(x.gap);
        end_b = x.ben ? int'(x.sb) + int'(x.lb) - 1 : -1;
        span  = ((end_a > end_b) ? end_a : end_b) + 6;
        for (int c = 0; c < span; c++) begin
            logic [NI-1:0] eq;
            logic [NO-1:0] ea, ex, eo;
            in_valid = '0;
            in_tap   = '0;
            // packet A: header at cycle 0, idle gap, then the rest
            if (c == 0) begin
                in_valid[x.pa] = 1'b1;
                in_tap[x.pa]   = mk_tap(2'b01, x.wa, x.ba, x.ma);
            end else if (c >= 1 + int'(x.gap) && c <= end_a) begin
                in_valid[x.pa] = 1'b1;
                in_tap[x.pa]   = mk_tap((c - int'(x.gap) == 1) ? 2'b10 : 2'b11, 1'b1, 4'hF, '1);
            end
            if (x.ben && c >= int'(x.sb) && c <= end_b) begin
                in_valid[x.pb] = 1'b1;
                if (c == int'(x.sb)) in_tap[x.pb] = mk_tap(2'b01, x.wb, x.bb, x.mb);
                else in_tap[x.pb] = mk_tap((c == int'(x.sb) + 1) ? 2'b10 : 2'b11, 1'b1, 4'hF, '1);
            end
            @(posedge clk);
            @(negedge clk);
            eq = '0; ea = '0; ex = '0; eo = '0;
            if (c <= end_a) eq[x.pa] = 1'b1;
            if (x.ben && c >= int'(x.sb) && c <= end_b) eq[x.pb] = 1'b1;
            for (int s = 1; s <= 3; s++) begin
                logic [NO-1:0] m;
                int cc;
                cc = c - s;
                m  = '0;
                if (cc >= 0 && cc <= end_a) m = m | x.ma;
                if (x.ben && cc >= int'(x.sb) && cc <= end_b) m = m | x.mb;
                if (s == 1) ea = m;
                if (s == 2) ex = m;
                if (s == 3) eo = m;
            end
            check_eq({"R2 ", vec_tag(v)}, $sformatf("v%0d c%0d gate_q", v, c), 16'(gate_q), 16'(eq));
            check_eq({"R4 ", vec_tag(v)}, $sformatf("v%0d c%0d gate_arb", v, c), 16'(gate_arb), 16'(ea));
            check_eq({"R5 ", vec_tag(v)}, $sformatf("v%0d c%0d gate_xbar", v, c), 16'(gate_xbar), 16'(ex));
            check_eq({"R5 ", vec_tag(v)}, $sformatf("v%0d c%0d gate_out", v, c), 16'(gate_out), 16'(eo));
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        rst      = 1'b1;
        in_valid = '0;
        in_tap   = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check_all_zero("R1 reset");
        rst = 1'b0;

        for (int v = 0; v < NV; v++) run_vector(v);

        // R7: stray address and data flits on idle inputs
        in_valid[3] = 1'b1; in_tap[3] = mk_tap(2'b11, 1'b1, 4'h8, '1);
        in_valid[4] = 1'b1; in_tap[4] = mk_tap(2'b10, 1'b1, 4'h8, '1);
        @(posedge clk);
        @(negedge clk);
        in_valid = '0; in_tap = '0;
        for (int k = 0; k < 5; k++) begin
            check_all_zero("R7 stray flit");
            @(posedge clk);
            @(negedge clk);
        end

        // R1: reset in the middle of a long write, then its remaining data flits are ignored (R7)
        in_valid[0] = 1'b1; in_tap[0] = mk_tap(2'b01, 1'b1, 4'd8, 7'h7F);
        @(posedge clk);
        @(negedge clk);
        in_tap[0] = mk_tap(2'b10, 1'b0, 4'd0, 7'h00);
        @(posedge clk);
        @(negedge clk);
        in_tap[0] = mk_tap(2'b11, 1'b0, 4'd0, 7'h00);
        @(posedge clk);
        @(negedge clk);
        check_eq("R2 pre-reset", "gate_q", 16'(gate_q), 16'h1);
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        check_all_zero("R1 mid-packet reset");
        rst = 1'b0;
        for (int k = 0; k < 6; k++) begin
            @(posedge clk);
            @(negedge clk);
            check_all_zero("R7 after reset");
        end
        in_valid = '0; in_tap = '0;

        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule